// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives stereo serial audio as a slave. Bit clock, word select and serial data all come from outside. The block runs entirely on the incoming bit clock and samples word select and data on its rising edge.

A two-bit format selector picks one of four framings:

- A delayed-MSB framing, in which the word starts one bit after each word-select change.
- Three right-justified framings, of 16, 20 and 24 bits. In these the last data bit of each channel sits just before the word-select change.

Each completed stereo frame, left half then right half, produces a left sample and a right sample. Both are 24 bits wide and are presented together, with a single-cycle valid strobe. Right-justified words are sign-extended. Delayed-MSB words are left-aligned, with zero fill at the LSB end.

After reset nothing is reported until the receiver has seen a word-select change and then a full left half followed by a full right half. This keeps partial words captured during lock-in out of the output stream.

Top module: `audrx_serial_rx`

## Requirements
- R1: `fmt_sel` selects the framing. 2'b00 is delayed-MSB, 2'b01 is right-justified 16-bit, 2'b10 is right-justified 20-bit and 2'b11 is right-justified 24-bit.
- R2: In delayed-MSB framing, the MSB is the data bit sampled on the second rising bit-clock edge after a word-select change. The bits that follow are taken MSB first, up to 24 of them. A half shorter than 24 bits gives a word left-aligned in bit 23 with zeros below it.
- R3: In delayed-MSB framing, data bits beyond the 24th in a half-frame have no effect on the reported sample.
- R4: In the right-justified framings of width N, the reported word is the last N bits sampled before the word-select change, MSB first. It is sign-extended from bit N-1 to 24 bits. Earlier bits of the half have no effect.
- R5: Word select low marks the left channel and high marks the right channel. A frame is reported once its right half ends, which is signalled by word select falling. Left and right are updated together.
- R6: `out_valid` is high for exactly one bit-clock cycle: the cycle after the rising edge that first samples word select low following a right half. Between pulses both sample outputs hold their values.
- R7: After reset both sample outputs are zero and `out_valid` is low. The following produce no report: a partial half seen before the first word-select change, and a right half not preceded by a full left half.
- R8: Each half-frame may last any number of bit clocks up to 32, provided it is at least N in the right-justified framings. Every frame sent is reported exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Serial bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lrck | input | 1 | Word select (low = left, high = right) |
| sdata | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing select, encoded as in R1 |
| left_out | output | 24 | Left sample of the last reported frame |
| right_out | output | 24 | Right sample of the last reported frame |
| out_valid | output | 1 | One-cycle strobe marking a new frame |

## Verification
Both samples and the strobe are due one bit-clock cycle after the rising edge that first samples word select low at the end of a right half. No other result takes longer.

The bench counts the bit slots it drives on falling edges. It notes the slot that starts each frame-closing left half and expects `out_valid` at the sample point exactly one slot later. That sample point lies 1 ns after a falling edge, so it is clear of the rising edge. The bench compares the samples in that same slot and requires the outputs to stay unchanged in every other slot.

Reset values are read right after the reset is released. The first-frame suppression is checked by starting every run with a partial half, and some runs also with an orphan right half.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S  = 2'b00,
        FMT_RJ16 = 2'b01,
        FMT_RJ20 = 2'b10,
        FMT_RJ24 = 2'b11
    } fmt_e;

    localparam int RJ_SHORT = 16;
    localparam int RJ_MID   = 20;
    localparam int RJ_LONG  = 24;

endpackage

// File: rtl/audrx_ws_track.sv
module audrx_ws_track (
    input  logic clk,
    input  logic rst_n,
    input  logic ws_i,
    output logic flip_o,
    output logic chan_o,
    output logic synced_o
);
    typedef struct packed {
        logic primed;
        logic ws;
        logic synced;
    } trk_t;

    trk_t s_q, s_d;
    logic flip;

    always_comb begin
        flip        = s_q.primed && (ws_i != s_q.ws);
        s_d.primed  = 1'b1;
        s_d.ws      = ws_i;
        s_d.synced  = s_q.synced | flip;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flip_o   = flip;
    assign chan_o   = s_q.ws;
    assign synced_o = s_q.synced;
endmodule

// File: rtl/audrx_shifter.sv
module audrx_shifter #(
    parameter int W     = 24,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_i,
    input  logic             flip_i,
    input  logic             i2s_i,
    output logic [W-1:0]     raw_o,
    output logic [CNT_W-1:0] fill_o
);
    typedef struct packed {
        logic [W-1:0]     sr;
        logic [CNT_W-1:0] fill;
    } sh_t;

    sh_t s_q, s_d;
    logic             take;
    logic [W-1:0]     shifted;
    logic [CNT_W-1:0] grown;

    always_comb begin
        take    = !i2s_i || (s_q.fill < CNT_W'(W));
        shifted = {s_q.sr[W-2:0], bit_i};
        grown   = (s_q.fill < CNT_W'(W)) ? s_q.fill + CNT_W'(1) : s_q.fill;

        // word closing at this edge: delayed-MSB framing still owns the current bit
        if (i2s_i && take) begin
            raw_o  = shifted;
            fill_o = grown;
        end else begin
            raw_o  = s_q.sr;
            fill_o = s_q.fill;
        end

        if (flip_i) begin
            if (i2s_i) begin
                s_d.sr   = '0;
                s_d.fill = '0;
            end else begin
                s_d.sr   = {{(W-1){1'b0}}, bit_i};
                s_d.fill = CNT_W'(1);
            end
        end else begin
            s_d.sr   = take ? shifted : s_q.sr;
            s_d.fill = grown;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/audrx_align.sv
module audrx_align
    import audrx_pkg::*;
#(
    parameter int W     = 24,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  fmt_e             fmt_i,
    input  logic [W-1:0]     raw_i,
    input  logic [CNT_W-1:0] fill_i,
    output logic [W-1:0]     word_o
);
    int span;

    always_comb begin
        case (fmt_i)
            FMT_RJ16: span = RJ_SHORT;
            FMT_RJ20: span = RJ_MID;
            default:  span = RJ_LONG;
        endcase

        word_o = '0;
        if (fmt_i == FMT_I2S) begin
            word_o = raw_i << (W - int'(fill_i));
        end else begin
            for (int k = 0; k < W; k++) begin
                word_o[k] = (k < span) ? raw_i[k] : raw_i[span-1];
            end
        end
    end
endmodule

// File: rtl/audrx_serial_rx.sv
module audrx_serial_rx
    import audrx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                lrck,
    input  logic                sdata,
    input  logic [1:0]          fmt_sel,
    output logic [SAMPLE_W-1:0] left_out,
    output logic [SAMPLE_W-1:0] right_out,
    output logic                out_valid
);
    localparam int CNT_W = $clog2(SAMPLE_W + 1);

    typedef struct packed {
        logic [SAMPLE_W-1:0] left_hold;
        logic                have_left;
        logic [SAMPLE_W-1:0] left;
        logic [SAMPLE_W-1:0] right;
        logic                valid;
    } fr_t;

    fmt_e                fmt;
    logic                flip, chan, synced;
    logic [SAMPLE_W-1:0] raw, word;
    logic [CNT_W-1:0]    fill;
    fr_t                 s_q, s_d;

    assign fmt = fmt_e'(fmt_sel);

    audrx_ws_track u_trk (
        .clk(bclk), .rst_n(rst_n), .ws_i(lrck),
        .flip_o(flip), .chan_o(chan), .synced_o(synced)
    );

    audrx_shifter #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_shift (
        .clk(bclk), .rst_n(rst_n), .bit_i(sdata), .flip_i(flip),
        .i2s_i(fmt == FMT_I2S), .raw_o(raw), .fill_o(fill)
    );

    audrx_align #(.W(SAMPLE_W), .CNT_W(CNT_W)) u_align (
        .fmt_i(fmt), .raw_i(raw), .fill_i(fill), .word_o(word)
    );

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        if (flip && synced) begin
            if (!chan) begin
                s_d.left_hold = word;
                s_d.have_left = 1'b1;
            end else if (s_q.have_left) begin
                s_d.left      = s_q.left_hold;
                s_d.right     = word;
                s_d.valid     = 1'b1;
                s_d.have_left = 1'b0;
            end
        end
    end

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign left_out  = s_q.left;
    assign right_out = s_q.right;
    assign out_valid = s_q.valid;
endmodule

// File: rtl/audrx_serial_rx_chk.sv
module audrx_serial_rx_chk #(
    parameter int W = 24
) (
    input logic         bclk,
    input logic         rst_n,
    input logic         lrck,
    input logic [1:0]   fmt_sel,
    input logic [W-1:0] left_out,
    input logic [W-1:0] right_out,
    input logic         out_valid
);
    assert_valid_pulse_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_hold_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        !out_valid |-> ($stable(left_out) && $stable(right_out)));

    assert_pair_after_fall_R5: assert property (@(posedge bclk) disable iff (!rst_n)
        out_valid |-> ($past(lrck) == 1'b0 && $past(lrck, 2) == 1'b1));

    assert_sext16_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        (out_valid && fmt_sel == 2'b01 && $past(fmt_sel) == 2'b01) |->
        (left_out[W-1:15] == {(W-15){left_out[15]}} &&
         right_out[W-1:15] == {(W-15){right_out[15]}}));

    assert_sext20_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        (out_valid && fmt_sel == 2'b10 && $past(fmt_sel) == 2'b10) |->
        (left_out[W-1:19] == {(W-19){left_out[19]}} &&
         right_out[W-1:19] == {(W-19){right_out[19]}}));

    assert_reset_clear_R7: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(rst_n) |-> (left_out == '0 && right_out == '0 && !out_valid));
endmodule

bind audrx_serial_rx audrx_serial_rx_chk #(.W(SAMPLE_W)) u_chk (
    .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .fmt_sel(fmt_sel),
    .left_out(left_out), .right_out(right_out), .out_valid(out_valid)
);

// File: tb/audrx_serial_rx_test.sv
`timescale 1ns/1ps
module audrx_serial_rx_test;
    logic        bclk = 1'b0, rst_n = 1'b0, lrck = 1'b0, sdata = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [23:0] left_out, right_out;
    logic        out_valid;

    always #2.5 bclk = ~bclk;

    audrx_serial_rx uut (
        .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
        .fmt_sel(fmt_sel), .left_out(left_out), .right_out(right_out),
        .out_valid(out_valid)
    );

    int total = 0, bad = 0;
    int sc = 0, due_sc = -1;
    bit pend = 0;
    logic prev_und = 1'b0;
    logic [23:0] q_left[$], q_right[$];
    logic [1:0] cur_fmt = 2'b00;
    int cur_h = 16;
    logic [23:0] last_l = '0, last_r = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int rj_len(input logic [1:0] f);
        return (f == 2'b01) ? 16 : (f == 2'b10) ? 20 : 24;
    endfunction

    // expected sample from the slots of one half (slot j at hb[j])
    function automatic logic [23:0] expect_word(input logic [1:0] f,
                                                input logic [31:0] hb, input int h);
        logic [23:0] r = '0;
        if (f == 2'b00) begin
            for (int j = 0; j < 24; j++) if (j < h) r[23-j] = hb[j];
        end else begin
            int n = rj_len(f);
            for (int k = 0; k < n; k++) r[n-1-k] = hb[h-n+k];
            for (int k = n; k < 24; k++) r[k] = r[n-1];
        end
        return r;
    endfunction

    task automatic drive_slot(input logic w, input logic b);
        @(negedge bclk);
        sc++;
        lrck  = w;
        sdata = (fmt_sel == 2'b00) ? prev_und : b;
        prev_und = b;
        if (pend && !w) begin
            due_sc = sc + 1;
            pend   = 0;
        end
    endtask

    task automatic drive_half(input logic w, input logic [31:0] hb, input int h);
        for (int j = 0; j < h; j++) drive_slot(w, hb[j]);
    endtask

    task automatic do_reset(input logic [1:0] f);
        @(negedge bclk);
        rst_n = 1'b0; fmt_sel = f; lrck = 1'b0; sdata = 1'b0;
        prev_und = 1'b0; pend = 0; due_sc = -1;
        q_left.delete(); q_right.delete();
        repeat (3) @(negedge bclk);
        rst_n = 1'b1;
        #1;
        check(left_out == '0 && right_out == '0 && !out_valid, "R7",
              "reset state", left_out | right_out | {23'b0, out_valid}, 24'h0);
    endtask

    task automatic run_group(input logic [1:0] f, input int h, input int nfr,
                             input bit lead_right, input bit directed);
        logic [31:0] hl, hr;
        do_reset(f);
        cur_fmt = f; cur_h = h;
        if (lead_right) begin
            drive_half(1'b0, $urandom, h);   // partial-looking left before sync
            drive_half(1'b1, $urandom, h);   // orphan right: must not report
        end else begin
            drive_half(1'b1, $urandom, h);
        end
        for (int i = 0; i < nfr; i++) begin
            hl = $urandom; hr = $urandom;
            if (directed && i == 0) begin
                if (f == 2'b00) begin
                    hl = 32'hFFFF_FFFF;
                    hr = 32'h0000_0001;
                end else begin
                    hl = 32'h1 << (h - rj_len(f));
                    hr = ~hl;
                end
            end
            q_left.push_back(expect_word(f, hl, h));
            q_right.push_back(expect_word(f, hr, h));
            drive_half(1'b0, hl, h);
            drive_half(1'b1, hr, h);
            pend = 1;
        end
        drive_half(1'b0, 32'h0, h);
        repeat (3) @(negedge bclk);
        check(q_left.size() == 0, "R8", "frames not reported",
              24'(q_left.size()), 24'h0);
    endtask

    always @(negedge bclk) begin
        #1;
        if (rst_n) begin
            bit exp_v;
            string t;
            exp_v = (sc == due_sc);
            if (exp_v || out_valid)
                check(out_valid == exp_v, "R6", "valid timing",
                      {23'b0, out_valid}, {23'b0, exp_v});
            if (out_valid) begin
                if (q_left.size() == 0) begin
                    check(1'b0, "R7", "unexpected frame", left_out, 24'h0);
                end else begin
                    logic [23:0] el, er;
                    el = q_left.pop_front();
                    er = q_right.pop_front();
                    t = (cur_fmt == 2'b00) ? ((cur_h > 24) ? "R1 R3 R5" : "R1 R2 R5")
                                           : "R1 R4 R5";
                    check(left_out == el, t, "left sample", left_out, el);
                    check(right_out == er, t, "right sample", right_out, er);
                end
            end else if (left_out !== last_l || right_out !== last_r) begin
                check(1'b0, "R6", "outputs moved without valid", left_out, last_l);
            end
        end
        last_l = left_out;
        last_r = right_out;
    end

    initial begin
        repeat (100000) @(posedge bclk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        run_group(2'b00, 32, 6, 1'b0, 1'b1);
        run_group(2'b00, 24, 6, 1'b0, 1'b1);
        run_group(2'b00, 16, 6, 1'b1, 1'b1);
        run_group(2'b00, 25, 4, 1'b0, 1'b0);
        run_group(2'b01, 16, 6, 1'b0, 1'b1);
        run_group(2'b01, 32, 6, 1'b1, 1'b1);
        run_group(2'b10, 20, 6, 1'b0, 1'b1);
        run_group(2'b10, 32, 4, 1'b0, 1'b1);
        run_group(2'b11, 24, 6, 1'b0, 1'b1);
        run_group(2'b11, 28, 4, 1'b1, 1'b1);
        for (int g = 0; g < 12; g++) begin
            logic [1:0] f;
            int h;
            f = 2'($urandom_range(0, 3));
            h = (f == 2'b00) ? int'($urandom_range(2, 32))
                             : int'($urandom_range(rj_len(f), 32));
            run_group(f, h, int'($urandom_range(3, 6)), 1'($urandom_range(0, 1)), 1'b0);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule